// File: doc/BRIEF.md
# Candidate plaintext byte filter

This block decides whether one 64-bit block-cipher output could be plaintext. It first XORs the word with one of two programmable 64-bit chaining masks. A sideband select bit sent with each candidate picks the mask. This step stands in for the chaining XOR of a chained cipher mode.

Each of the eight resulting bytes is then used as an address into a 256-bit table of acceptable byte values. A per-byte enable vector sets which bytes take part. The candidate is reported as a match only when every enabled byte addresses a set bit in the table.

Candidates arrive on a valid/ready stream and results leave on a second valid/ready stream, one register stage later. A result that the consumer does not take is held unchanged, and the input is stalled until it is taken. When a result is taken, a new candidate can be accepted in the same cycle, so the block runs at one candidate per clock. The table, masks and enables are static configuration inputs. They are sampled when a candidate is accepted.

Top module: `cand_byte_filter`

## Requirements
- R1: While reset (rst_n low) is asserted and right after its release, out_valid is 0 and in_ready is 1.
- R2: Byte i of in_word is bits [63-8i : 56-8i], so byte 0 is the most significant byte. Bit i of cfg_byte_en enables byte i, and bit i of out_pass reports byte i.
- R3: The checked byte value is (in_word XOR mask) for that byte. The mask is cfg_xor0 when in_sel is 0 and cfg_xor1 when in_sel is 1, and mask bytes use the same positions as word bytes.
- R4: A byte of value v hits when bit v of cfg_table is 1. This is bit v%8 of table byte v/8, where table byte k occupies bits [8k+7 : 8k].
- R5: out_match is 1 exactly when every enabled byte hits. If cfg_byte_en is all zeros, every candidate matches.
- R6: out_pass[i] is 1 when byte i is disabled or hits, and 0 when byte i is enabled and misses.
- R7: A candidate accepted at a clock edge (in_valid and in_ready both 1) has its result on out_valid, out_match and out_pass right after that same edge.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_match and out_pass stay unchanged.
- R9: in_ready is 1 whenever out_ready is 1, so a result can be taken and a new candidate accepted at the same edge. A result taken with no new candidate clears out_valid.
- R10: Changes to in_word or the configuration inputs after a candidate is accepted do not alter the held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Candidate present |
| in_ready | output | 1 | Block can take a candidate |
| in_word | input | 64 | Cipher output word |
| in_sel | input | 1 | Chaining mask select for this candidate |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_match | output | 1 | All enabled bytes hit the table |
| out_pass | output | 8 | Per-byte pass flags |
| cfg_table | input | 256 | Acceptable-value bitmap |
| cfg_xor0 | input | 64 | Chaining mask 0 |
| cfg_xor1 | input | 64 | Chaining mask 1 |
| cfg_byte_en | input | 8 | Per-byte check enable |

## Verification
Two events can fall on the same edge: the consumer taking a held result and the block accepting the next candidate. The bench provokes this in two ways. It streams candidates back to back with out_ready high. It also releases a stalled result while a new candidate, checked against a table that was changed during the stall, is waiting. It judges the overlap by checking two things: the old result never changed during the stall, and the new result reflects the new table and arrives on the very edge that drained the old one.

// File: rtl/filt_pkg.sv
`timescale 1ns/1ps
package filt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned TBL_W  = 1 << BYTE_W;

  // Bit offset of byte idx when byte 0 is the most significant.
  function automatic int unsigned byte_lsb(input int unsigned idx,
                                           input int unsigned nbytes);
    return (nbytes - 1 - idx) * BYTE_W;
  endfunction
endpackage

// File: rtl/filt_unmask.sv
`timescale 1ns/1ps
module filt_unmask
  import filt_pkg::*;
#(
  parameter int unsigned NBYTES = 8,
  localparam int unsigned WORD_W = NBYTES * BYTE_W
) (
  input  logic [WORD_W-1:0]              word,
  input  logic [WORD_W-1:0]              mask0,
  input  logic [WORD_W-1:0]              mask1,
  input  logic                           sel,
  output logic [NBYTES-1:0][BYTE_W-1:0]  bytes_o
);
  logic [WORD_W-1:0] chained;

  always_comb chained = word ^ (sel ? mask1 : mask0);

  for (genvar i = 0; i < NBYTES; i++) begin : g_split
    assign bytes_o[i] = chained[byte_lsb(i, NBYTES) +: BYTE_W];
  end
endmodule

// File: rtl/filt_lookup.sv
`timescale 1ns/1ps
module filt_lookup
  import filt_pkg::*;
(
  input  logic [BYTE_W-1:0] value,
  input  logic [TBL_W-1:0]  table_bits,
  input  logic              enable,
  output logic              pass
);
  always_comb pass = !enable || table_bits[value];
endmodule

// File: rtl/filt_out_stage.sv
`timescale 1ns/1ps
module filt_out_stage #(
  parameter int unsigned NBYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NBYTES-1:0] pass_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_match,
  output logic [NBYTES-1:0] out_pass
);
  logic take;

  always_comb begin
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_match <= 1'b0;
      out_pass  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_match <= &pass_in;
      out_pass  <= pass_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cand_byte_filter.sv
`timescale 1ns/1ps
module cand_byte_filter
  import filt_pkg::*;
#(
  parameter int unsigned NBYTES = 8,
  localparam int unsigned WORD_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_sel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_match,
  output logic [NBYTES-1:0] out_pass,
  input  logic [TBL_W-1:0]  cfg_table,
  input  logic [WORD_W-1:0] cfg_xor0,
  input  logic [WORD_W-1:0] cfg_xor1,
  input  logic [NBYTES-1:0] cfg_byte_en
);
  logic [NBYTES-1:0][BYTE_W-1:0] plain_bytes;
  logic [NBYTES-1:0]             byte_pass;

  filt_unmask #(.NBYTES(NBYTES)) u_unmask (
    .word    (in_word),
    .mask0   (cfg_xor0),
    .mask1   (cfg_xor1),
    .sel     (in_sel),
    .bytes_o (plain_bytes)
  );

  for (genvar i = 0; i < NBYTES; i++) begin : g_lookup
    filt_lookup u_lookup (
      .value      (plain_bytes[i]),
      .table_bits (cfg_table),
      .enable     (cfg_byte_en[i]),
      .pass       (byte_pass[i])
    );
  end

  filt_out_stage #(.NBYTES(NBYTES)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .pass_in   (byte_pass),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_match (out_match),
    .out_pass  (out_pass)
  );
endmodule

// File: rtl/filt_checker.sv
`timescale 1ns/1ps
module filt_checker #(
  parameter int unsigned NBYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_match,
  input logic [NBYTES-1:0] out_pass,
  input logic [NBYTES-1:0] cfg_byte_en
);
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_match) && $stable(out_pass))); // R8

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8

  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R9

  AST_NO_ENABLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (cfg_byte_en == '0)) |=> out_match); // R5

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (&(out_pass | $past(cfg_byte_en)))); // R6

  AST_MATCH_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_match == (&out_pass))); // R5
endmodule

bind cand_byte_filter filt_checker #(.NBYTES(NBYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_match   (out_match),
  .out_pass    (out_pass),
  .cfg_byte_en (cfg_byte_en)
);

// File: tb/cand_byte_filter_tb.sv
`timescale 1ns/1ps
module cand_byte_filter_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  in_word = '0;
  logic         in_sel = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         out_match;
  logic [7:0]   out_pass;
  logic [255:0] cfg_table = '0;
  logic [63:0]  cfg_xor0 = '0;
  logic [63:0]  cfg_xor1 = '0;
  logic [7:0]   cfg_byte_en = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cand_byte_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_sel(in_sel), .out_valid(out_valid),
    .out_ready(out_ready), .out_match(out_match), .out_pass(out_pass),
    .cfg_table(cfg_table), .cfg_xor0(cfg_xor0), .cfg_xor1(cfg_xor1),
    .cfg_byte_en(cfg_byte_en)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected result from the requirements (R2, R3, R4, R5, R6).
  task automatic expect_of(input logic [63:0] w, input logic sel,
                           output logic m, output logic [7:0] p);
    logic [63:0] x;
    x = w ^ (sel ? cfg_xor1 : cfg_xor0);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      b = x[(7 - i) * 8 +: 8];
      p[i] = !cfg_byte_en[i] || cfg_table[b];
    end
    m = &p;
  endtask

  // Drive at a negedge, result checked at the next negedge (R7).
  task automatic send_check(input logic [63:0] w, input logic sel, input string req);
    logic m;
    logic [7:0] p;
    in_word  = w;
    in_sel   = sel;
    in_valid = 1'b1;
    expect_of(w, sel, m, p);
    @(negedge clk);
    chk(out_valid == 1'b1, {req, " R7 valid"}, 64'(out_valid), 64'd1);
    chk(out_match == m, {req, " match"}, 64'(out_match), 64'(m));
    chk(out_pass == p, {req, " R6 pass map"}, 64'(out_pass), 64'(p));
  endtask

  function automatic logic [63:0] lfsr(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  initial begin
    logic [63:0] s;
    logic        hm;
    logic [7:0]  hp;
    logic        m2;
    logic [7:0]  p2;

    for (int v = 0; v < 256; v++) cfg_table[v] = ((v * 7 + 3) % 5) < 2;
    #2;
    chk(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1 ready after reset", 64'(in_ready), 64'd1);

    // R2 R4: every value in every byte position, one byte enabled at a time.
    for (int i = 0; i < 8; i++) begin
      cfg_byte_en = 8'(1 << i);
      for (int v = 0; v < 256; v++) begin
        logic [63:0] w;
        w = {8{8'(v) ^ 8'h5A}};
        w[(7 - i) * 8 +: 8] = 8'(v);
        send_check(w, 1'b0, "R2 R4 sweep");
      end
    end

    // R3 R5: both masks, all bytes enabled, pseudo-random words.
    cfg_byte_en = 8'hFF;
    cfg_xor0 = 64'h0123_4567_89AB_CDEF;
    cfg_xor1 = 64'hF0E1_D2C3_B4A5_9687;
    for (int v = 0; v < 256; v++) cfg_table[v] = (v % 3) != 0;
    s = 64'h1;
    for (int k = 0; k < 512; k++) begin
      s = lfsr(s);
      send_check(s, 1'(k), "R3 R5 masks");
    end
    // Candidates built to hit through each mask.
    send_check(cfg_xor0 ^ {8{8'd1}}, 1'b0, "R3 mask0 hit");
    send_check(cfg_xor1 ^ {8{8'd1}}, 1'b1, "R3 mask1 hit");
    send_check(cfg_xor1 ^ {8{8'd1}}, 1'b0, "R3 wrong mask");

    // R5: no bytes enabled on an all-zero table.
    cfg_table = '0;
    cfg_byte_en = 8'h00;
    send_check(64'hDEAD_BEEF_0000_FFFF, 1'b1, "R5 empty enable");
    cfg_byte_en = 8'h81;
    cfg_table[8'h00] = 1'b1;
    send_check(64'h00FF_FFFF_FFFF_FF00 ^ cfg_xor0, 1'b0, "R2 R5 ends only");

    // R8 R10 R9: stall, change inputs and table, then overlap drain and accept.
    cfg_xor0 = '0;
    cfg_byte_en = 8'hFF;
    for (int v = 0; v < 256; v++) cfg_table[v] = v[0];
    out_ready = 1'b0;
    send_check(64'h0101_0101_0101_0101, 1'b0, "R8 first");
    hm = out_match;
    hp = out_pass;
    in_word = 64'h0202_0202_0202_0202;
    cfg_table = ~cfg_table;
    expect_of(in_word, 1'b0, m2, p2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R8 stall ready", 64'(in_ready), 64'd0);
      chk(out_valid == 1'b1 && out_match == hm && out_pass == hp,
          "R8 R10 held", {55'd0, out_valid, out_pass}, {55'd1, hp});
    end
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R9 ready follows out_ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_match == m2 && out_pass == p2,
        "R9 R10 overlap result", {55'd0, out_match, out_pass}, {55'd0, m2, p2});
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 drain clears", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule